// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides an input sample clock by a programmable whole number between one and eight. It produces a divided clock with a fixed high/low split and a single-cycle clock-enable strobe that marks the start of each output period. A request line for a downstream duty-cycle stabilizer goes high automatically whenever the block actually divides.

An external alignment input can restart the divider at its defined initial phase. Several of these dividers fed from one clock and one alignment line therefore keep identical phases and sample together. A control word, loaded through a write strobe, picks the ratio and enables alignment. It also selects whether every alignment edge restarts the divider, or only the first one after each control write. A status output shows whether that single-use alignment is still pending.

Ratio changes are held back until the current output period ends or an alignment restarts the count. This prevents shortened pulses on the divided clock.

Top module: `clkdiv_align_top`

## Requirements
- R1: The control word field `cfg_wdata[2:0]` holds N-1. The divider then repeats every N input cycles, and `ce_o` is high for exactly one input cycle per period, at count zero.
- R2: For N above one, `clk_div_o` is high for ceil(N/2) input cycles starting at count zero, and low for the rest of the period.
- R3: With N equal to one, `clk_div_o` follows `clk_i` and `ce_o` stays high.
- R4: `stab_req_o` is high whenever the running ratio is not one, or when control bit 5 is set. It is low for ratio one with bit 5 clear.
- R5: Suppose `sync_i` rises before input edge k and the rise is accepted. Then edge k+2 restarts the count, and the cycle after that edge shows count zero (`ce_o` high, divided clock high).
- R6: With control bit 3 (alignment enable) clear, rising edges on `sync_i` leave the divider phase unchanged.
- R7: With bit 3 set and bit 4 clear (repeating mode), every rising edge on `sync_i` restarts the divider.
- R8: With bits 3 and 4 both set (single-use mode), a control write arms the block and `armed_o` goes high. The first rising edge on `sync_i` restarts the divider and clears `armed_o`. Later edges are ignored until the next control write.
- R9: A ratio written in the middle of a period takes effect only at the next period wrap or the next accepted alignment.
- R10: After reset, the ratio is one, alignment is disabled, `armed_o` and `stab_req_o` are low, and `ce_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input sample clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_i release |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 6 | Control word: [2:0] ratio minus one, [3] alignment enable, [4] single-use mode, [5] force stabilizer request |
| sync_i | input | 1 | Asynchronous alignment input, rising edge active |
| clk_div_o | output | 1 | Divided clock |
| ce_o | output | 1 | One-cycle strobe at the start of each period |
| stab_req_o | output | 1 | Duty-cycle stabilizer request |
| armed_o | output | 1 | Single-use alignment pending |

## Verification
The assertions assume two things about the inputs. First, a control write never lands in the same cycle as an accepted alignment edge. Second, `sync_i` holds each level long enough to pass the two-stage synchronizer. The stimulus keeps to both: every alignment pulse stays high for four cycles and low for at least three, and control writes are issued only while no alignment edge is in flight. The bench predicts every output from a cycle model written from the requirements. That model covers ratio changes at period boundaries and restarts at alignment edges, so phase drift or a missed restart shows up as a mismatch on the ports.

// File: rtl/clkdiv_align_pkg.sv
package clkdiv_align_pkg;
    localparam int unsigned RATIO_W = 3;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic   stab_force;
        logic   one_shot;
        logic   sync_en;
        ratio_t ratio_m1;
    } cfg_t;

    localparam int unsigned CFG_W = $bits(cfg_t);
    localparam cfg_t CFG_RESET = '0;
endpackage

// File: rtl/clkdiv_sync_edge.sv
module clkdiv_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-1:0], async_i};
        rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R5: a detected rise is a single-cycle event
    a_r5_rise_single: assert property (@(posedge clk_i) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_align_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n,
    input  logic wr_i,
    input  cfg_t wdata_i,
    input  logic rise_i,
    output cfg_t cfg_o,
    output logic armed_o,
    output logic sync_valid_o
);
    typedef struct packed {
        cfg_t cfg;
        logic armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        sync_valid_o = st_q.cfg.sync_en & rise_i & (~st_q.cfg.one_shot | st_q.armed);
        if (sync_valid_o && st_q.cfg.one_shot) begin
            st_d.armed = 1'b0;
        end
        if (wr_i) begin
            st_d.cfg   = wdata_i;
            st_d.armed = wdata_i.sync_en & wdata_i.one_shot;
        end
        cfg_o   = st_q.cfg;
        armed_o = st_q.armed;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= CFG_RESET;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a consumed single-use alignment disarms the block
    a_r8_disarm: assert property (@(posedge clk_i) disable iff (!rst_n)
        (sync_valid_o && st_q.cfg.one_shot && !wr_i) |=> !armed_o);

    // R8: arming only comes from a control write
    a_r8_arm_by_write: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(armed_o) |-> $past(wr_i));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_align_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_n,
    input  ratio_t ratio_i,
    input  logic   sync_i,
    output ratio_t act_o,
    output logic   div_o,
    output logic   ce_o
);
    localparam logic [RATIO_W:0] TWO = (RATIO_W+1)'(2);

    typedef struct packed {
        ratio_t cnt;
        ratio_t act;
        logic   div;
        logic   ce;
    } st_t;

    st_t st_d, st_q;
    logic [RATIO_W:0] high_len;

    always_comb begin
        st_d = st_q;
        if (sync_i || st_q.cnt == st_q.act) begin
            st_d.cnt = '0;
            st_d.act = ratio_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        high_len = ({1'b0, st_d.act} + TWO) >> 1;
        st_d.div = {1'b0, st_d.cnt} < high_len;
        st_d.ce  = (st_d.cnt == '0);
        act_o    = st_q.act;
        div_o    = st_q.div;
        ce_o     = st_q.ce;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.act <= CFG_RESET.ratio_m1;
            st_q.div <= 1'b1;
            st_q.ce  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: counter never passes the running limit
    a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
        st_q.cnt <= st_q.act);

    // R9: the running ratio changes only at count zero
    a_r9_switch_at_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
        !$stable(st_q.act) |-> st_q.cnt == '0);

    // R1: strobe lasts one cycle when dividing
    a_r1_ce_single: assert property (@(posedge clk_i) disable iff (!rst_n)
        (ce_o && st_q.act != '0 && !sync_i) |=> !ce_o);
endmodule

// File: rtl/clkdiv_align_top.sv
module clkdiv_align_top
    import clkdiv_align_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             sync_i,
    output logic             clk_div_o,
    output logic             ce_o,
    output logic             stab_req_o,
    output logic             armed_o
);
    logic   rise;
    logic   sync_valid;
    cfg_t   cfg;
    ratio_t act;
    logic   div_reg;

    clkdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .async_i (sync_i),
        .rise_o  (rise)
    );

    clkdiv_cfg u_cfg (
        .clk_i        (clk_i),
        .rst_n        (rst_n),
        .wr_i         (cfg_wr_i),
        .wdata_i      (cfg_t'(cfg_wdata_i)),
        .rise_i       (rise),
        .cfg_o        (cfg),
        .armed_o      (armed_o),
        .sync_valid_o (sync_valid)
    );

    clkdiv_core u_core (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .ratio_i (cfg.ratio_m1),
        .sync_i  (sync_valid),
        .act_o   (act),
        .div_o   (div_reg),
        .ce_o    (ce_o)
    );

    always_comb begin
        clk_div_o  = (act == '0) ? clk_i : div_reg;
        stab_req_o = cfg.stab_force | (act != '0);
    end

    // R5: an accepted alignment restarts at the initial phase
    a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_n)
        sync_valid |=> (ce_o && div_reg));

    // R6: without enable no edge is accepted, across the cfg/edge boundary
    a_r6_disabled: assert property (@(posedge clk_i) disable iff (!rst_n)
        (rise && !cfg.sync_en) |-> !sync_valid);
endmodule

// File: tb/clkdiv_align_top_test.sv
module clkdiv_align_top_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       sync_in = 1'b0;
    logic       clk_div, ce, stab, armed;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // bench cycle model
    int ph = 0, nn = 1, pend = 1;
    bit m_en = 0, m_once = 0, m_force = 0, m_armed = 0;
    int sync_cd = 0;
    bit wr_pend = 0;
    logic [5:0] wr_val = '0;

    always #(CLK_P/2) clk = ~clk;

    clkdiv_align_top uut (
        .clk_i       (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_wdata_i (cfg_wdata),
        .sync_i      (sync_in),
        .clk_div_o   (clk_div),
        .ce_o        (ce),
        .stab_req_o  (stab),
        .armed_o     (armed)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (ph=%0d N=%0d)", req, what, act, exp, ph, nn);
        end
    endtask

    task automatic cyc(input string req);
        bit v;
        @(posedge clk);
        v = 0;
        if (sync_cd > 0) begin
            sync_cd--;
            if (sync_cd == 0) v = m_en && (!m_once || m_armed);
        end
        if (v || ph == nn - 1) begin
            ph = 0;
            nn = pend;
        end else begin
            ph++;
        end
        if (v && m_once) m_armed = 0;
        if (wr_pend) begin
            pend    = int'(wr_val[2:0]) + 1;
            m_en    = wr_val[3];
            m_once  = wr_val[4];
            m_force = wr_val[5];
            m_armed = wr_val[3] & wr_val[4];
            wr_pend = 0;
        end
        @(negedge clk);
        #1;
        check(req, "clk_div", clk_div, (nn == 1) ? 1'b0 : (ph < (nn + 1) / 2));
        check(req, "ce", ce, (nn == 1) ? 1'b1 : (ph == 0));
        check(req, "stab_req", stab, m_force || nn != 1);
        check(req, "armed", armed, m_armed);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    task automatic write_cfg(input logic [5:0] val, input string req);
        cfg_wr    = 1'b1;
        cfg_wdata = val;
        wr_val    = val;
        wr_pend   = 1;
        cyc(req);
        cfg_wr    = 1'b0;
    endtask

    task automatic pulse_sync(input string req);
        sync_in = 1'b1;
        sync_cd = 3;
        run(4, req);
        sync_in = 1'b0;
        run(3, req);
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        check("R10", "ce", ce, 1'b1);
        check("R10", "armed", armed, 1'b0);
        check("R10", "stab_req", stab, 1'b0);
        @(posedge clk);
        #2;
        check("R10", "clk_div high phase", clk_div, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        run(3, "R10");
    endtask

    task automatic t_ratio_one;
        write_cfg(6'b000_000, "R3");
        run(4, "R3");
        @(posedge clk);
        #2;
        check("R3", "clk_div follows clock high", clk_div, 1'b1);
        check("R3", "ce held high", ce, 1'b1);
        // keep the model aligned: one posedge consumed above
        ph = 0;
        @(negedge clk);
        #1;
        check("R3", "clk_div follows clock low", clk_div, 1'b0);
        check("R4", "stab low at ratio one", stab, 1'b0);
    endtask

    task automatic t_even;
        write_cfg(6'b001_011, "R1");
        run(12, "R2");
        check("R4", "stab high when dividing", stab, 1'b1);
    endtask

    task automatic t_midchange;
        while (ph != 1) cyc("R9");
        write_cfg(6'b001_110, "R9");
        run(3, "R9");
        run(14, "R2");
    endtask

    task automatic t_repeat_sync;
        write_cfg(6'b001_100, "R7");
        run(3, "R7");
        pulse_sync("R5");
        run(2, "R7");
        pulse_sync("R7");
        run(5, "R7");
    endtask

    task automatic t_disabled;
        write_cfg(6'b000_101, "R6");
        run(2, "R6");
        pulse_sync("R6");
        run(4, "R6");
    endtask

    task automatic t_one_shot;
        write_cfg(6'b011_010, "R8");
        check("R8", "armed after write", armed, 1'b1);
        run(2, "R8");
        pulse_sync("R8");
        check("R8", "disarmed after use", armed, 1'b0);
        run(1, "R8");
        pulse_sync("R8");
        run(2, "R8");
        write_cfg(6'b011_010, "R8");
        check("R8", "rearmed by write", armed, 1'b1);
        pulse_sync("R8");
        run(3, "R8");
    endtask

    task automatic t_force_and_max;
        write_cfg(6'b101_000, "R4");
        run(3, "R4");
        check("R4", "forced stab at ratio one", stab, 1'b1);
        write_cfg(6'b001_111, "R1");
        run(18, "R1");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_ratio_one();
        t_even();
        t_midchange();
        t_repeat_sync();
        t_disabled();
        t_one_shot();
        t_force_and_max();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule